// File: doc/BRIEF.md
# Hot-Swap Startup Sequencer

This block is the digital sequencer that powers up a hot-plugged board through an external pass switch. It does not touch analog quantities. Comparators elsewhere report each condition as a flag: supply above its undervoltage level, load-probe voltage reached, output below 72% of the breaker level, gate at 90% of full drive, and an overcurrent request. The block turns these flags into a gate command, a load-probe switch enable and a power-good flag.

After the supply has been good for a settling period, the block checks the load for a short with a current probe. It then releases the gate in two phases, first held low and then floating, and ramps it under control. The gate snaps to full drive once the output has come down, and power-good follows after a further delay. A parameter picks the fault handling. In autoretry mode the block waits and probes again. In latched mode it waits until the supply has been lost for a qualified time. All times are parameters counted in clock cycles.

Top module: `hs_seq`

## Requirements
- R1: While reset is held, gate_cmd is PULLDOWN (2'b00), probe_en is 0 and pgood is 0.
- R2: probe_en rises exactly T_START cycles after uv_ok has been sampled high on consecutive clocks. Any low sample of uv_ok in the startup-delay phase restarts the full count.
- R3: probe_en stays high for at most T_PROBE cycles. A high probe_ok ends the probe on the next clock with a pass, and a window that expires without probe_ok is a failed probe.
- R4: After a pass, gate_cmd is PULLDOWN for T_HOLD cycles, then FLOAT (2'b01) for T_FLOAT cycles, then RAMP (2'b10).
- R5: During RAMP, a high out_low moves gate_cmd to FULL (2'b11) on the next clock. pgood rises T_PGOOD cycles later and is only ever high while gate_cmd is FULL.
- R6: During RAMP, gate_90 high with out_low low pulls gate_cmd to PULLDOWN on the next clock, keeps pgood low and starts fault handling.
- R7: In autoretry mode (LATCHED=0), a failed probe is followed by PROBE_MULT*T_PROBE cycles with the gate pulled down and the probe off, and then a new probe.
- R8: In autoretry mode, a ramp fault or an overcurrent fault is followed by T_RETRY cycles of pulldown with the probe off, and then a new probe.
- R9: In latched mode (LATCHED=1), any fault holds the block pulled down, with the probe off, for as long as uv_ok does not stay low for T_UVDROP cycles. Once it has, the block restarts through the startup delay and a new probe.
- R10: uv_ok sampled low on T_UVDROP consecutive clocks, in any phase after the startup delay, forces PULLDOWN and pgood low one clock later and returns the block to the startup delay. Shorter dips have no effect on those phases.
- R11: ovc_fault high while gate_cmd is FULL, with or without pgood, pulls the gate down and drops pgood on the next clock.
- R12: In every fault-wait state, gate_cmd is PULLDOWN and both pgood and probe_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_ok | input | 1 | Supply above the undervoltage threshold |
| probe_ok | input | 1 | Load voltage reached during the probe |
| out_low | input | 1 | Output below 72% of the breaker threshold |
| gate_90 | input | 1 | Gate at 90% of full enhancement |
| ovc_fault | input | 1 | Breaker or short-circuit fault request |
| gate_cmd | output | 2 | Gate command: 00 pulldown, 01 float, 10 ramp, 11 full |
| probe_en | output | 1 | Load-probe current switch enable |
| pgood | output | 1 | Power-good flag |

## Verification
The bench measures every phase length to the exact cycle. A timer reloaded one cycle early or late shows up as a probe, hold, float, power-good or retry window that is off by one. It drops uv_ok for one cycle less than the qualification time, which a design with a miscounted filter would treat as a power loss. It also drops uv_ok once in the middle of the startup delay, which a design that keeps counting would answer with an early probe. In latched mode it waits well past the retry time and applies a short dip, so a design that retries by itself or clears on any dip would probe again too soon. Both the failed-probe retry and the overcurrent retry are timed, which exposes a design that swaps the two wait lengths.

// File: rtl/hs_pkg.sv
// Shared types for the hot-swap sequencer.
package hs_pkg;
    // Gate command encoding seen at the top-level port.
    typedef enum logic [1:0] {
        G_PULLDOWN = 2'b00,
        G_FLOAT    = 2'b01,
        G_RAMP     = 2'b10,
        G_FULL     = 2'b11
    } gate_cmd_t;

    // Sequencer phases.
    typedef enum logic [3:0] {
        S_DELAY, S_PROBE, S_HOLD, S_FLOAT, S_RAMP,
        S_FULL, S_ON, S_RETRY, S_LATCH
    } hs_state_t;
endpackage

// File: rtl/hs_uv_filter.sv
// Qualifies loss of supply: uv_lost goes high once uv_ok has been sampled
// low on N consecutive clocks and stays high while it remains low.
// Assumes N >= 1.
module hs_uv_filter #(
    parameter int N = 75000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_ok,
    output logic uv_lost
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples, saturating at N.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (uv_ok)
            low_cnt <= '0;
        else if (low_cnt != CW'(N))
            low_cnt <= low_cnt + 1'b1;
    end

    assign uv_lost = (low_cnt == CW'(N));
endmodule

// File: rtl/hs_timer.sv
// Shared down-counter for phase lengths. A load sets the count; otherwise
// it decrements to zero and stops. expired is high at zero.
// Assumes loads use (cycles - 1), giving a phase of exactly that many cycles.
module hs_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Load or count down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/hs_seq.sv
// Hot-swap startup sequencer: startup delay, load probe, two-phase gate
// release, controlled ramp, power-good, and autoretry or latched fault
// handling. All times are clock cycles. Assumes every time parameter >= 1
// and that the inputs are already synchronous to clk.
module hs_seq #(
    parameter int T_START    = 11000000,
    parameter int T_PROBE    = 11000000,
    parameter int PROBE_MULT = 16,
    parameter int T_HOLD     = 17500,
    parameter int T_FLOAT    = 32500,
    parameter int T_PGOOD    = 63000,
    parameter int T_UVDROP   = 75000,
    parameter int T_RETRY    = 175000000,
    parameter bit LATCHED    = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_ok,
    input  logic       probe_ok,
    input  logic       out_low,
    input  logic       gate_90,
    input  logic       ovc_fault,
    output logic [1:0] gate_cmd,
    output logic       probe_en,
    output logic       pgood
);
    import hs_pkg::*;

    localparam int T_PRB_RETRY = T_PROBE * PROBE_MULT;
    localparam int M1 = (T_START > T_PRB_RETRY) ? T_START : T_PRB_RETRY;
    localparam int M2 = (M1 > T_RETRY) ? M1 : T_RETRY;
    localparam int M3 = (T_HOLD > T_FLOAT) ? T_HOLD : T_FLOAT;
    localparam int M4 = (M3 > T_PGOOD) ? M3 : T_PGOOD;
    localparam int TMAX = (M2 > M4) ? M2 : M4;
    localparam int TW = $clog2(TMAX + 1);

    localparam logic [TW-1:0] LD_START  = TW'(T_START - 1);
    localparam logic [TW-1:0] LD_PROBE  = TW'(T_PROBE - 1);
    localparam logic [TW-1:0] LD_HOLD   = TW'(T_HOLD - 1);
    localparam logic [TW-1:0] LD_FLOAT  = TW'(T_FLOAT - 1);
    localparam logic [TW-1:0] LD_PGOOD  = TW'(T_PGOOD - 1);
    localparam logic [TW-1:0] LD_PRBRT  = TW'(T_PRB_RETRY - 1);
    localparam logic [TW-1:0] LD_CBRT   = TW'(T_RETRY - 1);

    hs_state_t       st, st_nxt;
    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_done;
    logic            uv_lost;

    hs_uv_filter #(.N(T_UVDROP)) u_uvf (
        .clk     (clk),
        .rst_n   (rst_n),
        .uv_ok   (uv_ok),
        .uv_lost (uv_lost)
    );

    hs_timer #(.W(TW), .RST_VAL(T_START - 1)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // Fault destinations differ by recovery mode.
    hs_state_t       probe_fail_st, trip_st;
    logic            probe_fail_ld, trip_ld;
    generate
        if (LATCHED) begin : g_latched
            assign probe_fail_st = S_LATCH;
            assign trip_st       = S_LATCH;
            assign probe_fail_ld = 1'b0;
            assign trip_ld       = 1'b0;
        end else begin : g_retry
            assign probe_fail_st = S_RETRY;
            assign trip_st       = S_RETRY;
            assign probe_fail_ld = 1'b1;
            assign trip_ld       = 1'b1;
        end
    endgenerate

    // Next-phase and timer-load decision.
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_val  = LD_START;
        if (uv_lost && st != S_DELAY) begin
            st_nxt   = S_DELAY;
            tmr_load = 1'b1;
            tmr_val  = LD_START;
        end else begin
            case (st)
                S_DELAY: begin
                    if (!uv_ok) begin
                        tmr_load = 1'b1;
                        tmr_val  = LD_START;
                    end else if (tmr_done) begin
                        st_nxt   = S_PROBE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_PROBE;
                    end
                end
                S_PROBE: begin
                    if (probe_ok) begin
                        st_nxt   = S_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = LD_HOLD;
                    end else if (tmr_done) begin
                        st_nxt   = probe_fail_st;
                        tmr_load = probe_fail_ld;
                        tmr_val  = LD_PRBRT;
                    end
                end
                S_HOLD: begin
                    if (tmr_done) begin
                        st_nxt   = S_FLOAT;
                        tmr_load = 1'b1;
                        tmr_val  = LD_FLOAT;
                    end
                end
                S_FLOAT: begin
                    if (tmr_done)
                        st_nxt = S_RAMP;
                end
                S_RAMP: begin
                    if (out_low) begin
                        st_nxt   = S_FULL;
                        tmr_load = 1'b1;
                        tmr_val  = LD_PGOOD;
                    end else if (gate_90) begin
                        st_nxt   = trip_st;
                        tmr_load = trip_ld;
                        tmr_val  = LD_CBRT;
                    end
                end
                S_FULL: begin
                    if (ovc_fault) begin
                        st_nxt   = trip_st;
                        tmr_load = trip_ld;
                        tmr_val  = LD_CBRT;
                    end else if (tmr_done) begin
                        st_nxt = S_ON;
                    end
                end
                S_ON: begin
                    if (ovc_fault) begin
                        st_nxt   = trip_st;
                        tmr_load = trip_ld;
                        tmr_val  = LD_CBRT;
                    end
                end
                S_RETRY: begin
                    if (tmr_done) begin
                        st_nxt   = S_PROBE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_PROBE;
                    end
                end
                S_LATCH: st_nxt = S_LATCH;
                default: begin
                    st_nxt   = S_DELAY;
                    tmr_load = 1'b1;
                    tmr_val  = LD_START;
                end
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_DELAY;
        else
            st <= st_nxt;
    end

    // Output decode from the phase.
    always_comb begin
        case (st)
            S_FLOAT:      gate_cmd = G_FLOAT;
            S_RAMP:       gate_cmd = G_RAMP;
            S_FULL, S_ON: gate_cmd = G_FULL;
            default:      gate_cmd = G_PULLDOWN;
        endcase
        probe_en = (st == S_PROBE);
        pgood    = (st == S_ON);
    end
endmodule

// File: rtl/hs_seq_chk.sv
// Protocol checker for hs_seq, attached by bind. Watches ports only and
// keeps its own count of consecutive low uv_ok samples.
module hs_seq_chk #(
    parameter int T_UVDROP = 75000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       uv_ok,
    input logic [1:0] gate_cmd,
    input logic       probe_en,
    input logic       pgood
);
    import hs_pkg::*;

    localparam int CW = $clog2(T_UVDROP + 3);
    logic [CW-1:0] lows;

    // Consecutive low samples of uv_ok, saturating above the drop time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lows <= '0;
        else if (uv_ok)
            lows <= '0;
        else if (lows <= CW'(T_UVDROP))
            lows <= lows + 1'b1;
    end

    // R5: power-good only with the gate fully enhanced.
    p_pgood_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> gate_cmd == G_FULL);

    // R5: power-good rises only after a cycle at full drive.
    p_pgood_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(gate_cmd) == G_FULL);

    // R12: probing only with the gate pulled down and no power-good.
    p_probe_pd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        probe_en |-> (gate_cmd == G_PULLDOWN && !pgood));

    // R5: full drive is entered only from the ramp.
    p_full_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cmd == G_FULL && $past(gate_cmd) != G_FULL) |-> $past(gate_cmd) == G_RAMP);

    // R4: ramp is entered only from float.
    p_ramp_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cmd == G_RAMP && $past(gate_cmd) != G_RAMP) |-> $past(gate_cmd) == G_FLOAT);

    // R4: float is entered only from pulldown.
    p_float_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cmd == G_FLOAT && $past(gate_cmd) != G_FLOAT) |-> $past(gate_cmd) == G_PULLDOWN);

    // R10: a qualified supply loss leaves the gate pulled down.
    p_uv_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lows > CW'(T_UVDROP)) |-> (gate_cmd == G_PULLDOWN && !pgood));
endmodule

bind hs_seq hs_seq_chk #(.T_UVDROP(T_UVDROP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .uv_ok    (uv_ok),
    .gate_cmd (gate_cmd),
    .probe_en (probe_en),
    .pgood    (pgood)
);

// File: tb/sim_hs_seq.sv
// Directed bench: u0 runs autoretry, u1 runs latched, both on shared inputs.
module sim_hs_seq;
    localparam int ST = 20, PR = 16, MU = 16, HO = 5, FL = 7, PG = 9, UV = 6, RT = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_ok = 1'b1, probe_ok = 1'b0, out_low = 1'b0, gate_90 = 1'b0, ovc_fault = 1'b0;
    logic [1:0] g0, g1;
    logic pe0, pe1, pg0, pg1;
    int checks = 0, fails = 0, cyc = 0;
    int sel = 0;
    logic [1:0] gs;
    logic pes, pgs;

    always #10 clk = ~clk;

    hs_seq #(.T_START(ST), .T_PROBE(PR), .PROBE_MULT(MU), .T_HOLD(HO), .T_FLOAT(FL),
             .T_PGOOD(PG), .T_UVDROP(UV), .T_RETRY(RT), .LATCHED(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .probe_ok(probe_ok), .out_low(out_low),
        .gate_90(gate_90), .ovc_fault(ovc_fault), .gate_cmd(g0), .probe_en(pe0), .pgood(pg0));

    hs_seq #(.T_START(ST), .T_PROBE(PR), .PROBE_MULT(MU), .T_HOLD(HO), .T_FLOAT(FL),
             .T_PGOOD(PG), .T_UVDROP(UV), .T_RETRY(RT), .LATCHED(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .probe_ok(probe_ok), .out_low(out_low),
        .gate_90(gate_90), .ovc_fault(ovc_fault), .gate_cmd(g1), .probe_en(pe1), .pgood(pg1));

    always_comb begin
        gs  = (sel == 0) ? g0 : g1;
        pes = (sel == 0) ? pe0 : pe1;
        pgs = (sel == 0) ? pg0 : pg1;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit cur(input int mode);
        case (mode)
            0: return pes;
            1: return gs == 2'b00 && !pes && !pgs;
            2: return gs == 2'b01;
            default: return gs == 2'b11 && !pgs;
        endcase
    endfunction

    task automatic run_len(input int mode, output int n);
        n = 0;
        while (cur(mode) && n < 2000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; uv_ok = 1'b1; probe_ok = 1'b0; out_low = 1'b0;
        gate_90 = 1'b0; ovc_fault = 1'b0;
        repeat (3) @(negedge clk);
        chk(gs == 2'b00 && !pes && !pgs, "R1 reset outputs", {gs, pes, pgs}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_probe(input string tag, input int exp);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pes && n < 3000);
        chk(n == exp, tag, n, exp);
    endtask

    task automatic pass_to_ramp();
        int n;
        probe_ok = 1'b1;
        @(negedge clk);
        probe_ok = 1'b0;
        chk(!pes && gs == 2'b00, "R3 probe pass ends probe", pes, 0);
        run_len(1, n); chk(n == HO, "R4 hold length", n, HO);
        run_len(2, n); chk(n == FL, "R4 float length", n, FL);
        chk(gs == 2'b10, "R4 ramp after float", gs, 2);
    endtask

    task automatic bring_on();
        int n;
        apply_reset();
        wait_probe("R2 startup delay", ST);
        pass_to_ramp();
        out_low = 1'b1;
        @(negedge clk);
        run_len(3, n); chk(n == PG, "R5 power-good delay", n, PG);
        chk(pgs && gs == 2'b11, "R5 power-good asserted", pgs, 1);
    endtask

    task automatic t_startup();
        sel = 0; bring_on();
    endtask

    task automatic t_probe_fail_auto();
        int n;
        sel = 0; apply_reset();
        wait_probe("R2 startup delay", ST);
        run_len(0, n); chk(n == PR, "R3 probe window", n, PR);
        run_len(1, n); chk(n == MU * PR, "R7 probe retry wait", n, MU * PR);
        chk(pes, "R7 probe rerun", pes, 1);
    endtask

    task automatic t_ramp_fault_auto();
        int n;
        sel = 0; apply_reset();
        wait_probe("R2 startup delay", ST);
        pass_to_ramp();
        gate_90 = 1'b1;
        @(negedge clk);
        gate_90 = 1'b0;
        chk(gs == 2'b00 && !pgs, "R6 ramp fault pulldown", gs, 0);
        run_len(1, n); chk(n == RT, "R8 ramp-fault retry wait", n, RT);
        chk(pes, "R8 probe after retry", pes, 1);
    endtask

    task automatic t_ovc_auto();
        int n;
        sel = 0; bring_on();
        ovc_fault = 1'b1;
        @(negedge clk);
        ovc_fault = 1'b0;
        chk(gs == 2'b00 && !pgs, "R11 overcurrent trip", {gs, pgs}, 0);
        run_len(1, n); chk(n == RT, "R8 overcurrent retry wait R12", n, RT);
    endtask

    task automatic t_uv();
        int n = 0;
        int bad = 0;
        sel = 0; bring_on();
        uv_ok = 1'b0;
        repeat (UV - 1) @(negedge clk);
        uv_ok = 1'b1;
        repeat (5) begin
            @(negedge clk);
            if (!pgs) bad++;
        end
        chk(bad == 0, "R10 short dip ignored", bad, 0);
        uv_ok = 1'b0;
        do begin
            @(negedge clk);
            n++;
        end while (gs != 2'b00 && n < 100);
        chk(n == UV + 1, "R10 qualified drop latency", n, UV + 1);
        chk(!pgs, "R10 pgood dropped", pgs, 0);
        repeat (10) @(negedge clk);
        uv_ok = 1'b1;
        wait_probe("R10 restart through delay", ST);
        // Dip inside the startup delay restarts the count.
        apply_reset();
        repeat (10) @(negedge clk);
        uv_ok = 1'b0;
        @(negedge clk);
        uv_ok = 1'b1;
        wait_probe("R2 delay restarted by dip", ST);
    endtask

    task automatic t_latch();
        int bad = 0;
        int n;
        sel = 1; apply_reset();
        wait_probe("R2 startup delay", ST);
        pass_to_ramp();
        gate_90 = 1'b1;
        @(negedge clk);
        gate_90 = 1'b0;
        repeat (3 * RT) begin
            if (!(gs == 2'b00 && !pes && !pgs)) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9 R12 latched hold", bad, 0);
        uv_ok = 1'b0;
        repeat (UV - 1) @(negedge clk);
        uv_ok = 1'b1;
        bad = 0;
        repeat (ST + 10) begin
            @(negedge clk);
            if (pes || gs != 2'b00) bad++;
        end
        chk(bad == 0, "R9 short dip keeps latch", bad, 0);
        uv_ok = 1'b0;
        repeat (UV + 2) @(negedge clk);
        uv_ok = 1'b1;
        wait_probe("R9 latch cleared restart", ST);
        run_len(0, n); chk(n == PR, "R3 latched probe window", n, PR);
        bad = 0;
        repeat (MU * PR + 20) begin
            if (pes || gs != 2'b00) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R9 failed probe latched", bad, 0);
    endtask

    initial begin
        t_startup();
        t_probe_fail_auto();
        t_ramp_fault_auto();
        t_ovc_auto();
        t_uv();
        t_latch();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule